// File: doc/BRIEF.md
# Starvation-Aware Command Queue Arbiter

This block buffers memory transactions (read or write, with a transaction ID, a chip select and an address) in a small pool of slots. Each cycle it presents one of them toward the memory side. Normally the longest-waiting entry is offered. Every entry also carries an aging countdown, loaded when the entry is accepted. Once the countdown reaches zero, the entry outranks all entries that have not yet aged out.

The countdown load value comes from three configuration inputs. The default is a 12-bit timeout. A transaction whose ID equals the configured priority ID is loaded with a shorter priority count instead. When the adaptive mode is enabled and the fast pin is high at acceptance, the fast priority count is used in its place. The block also reports, for each chip select, whether any queued entry targets that chip.

Top module: `cmdq_arb`

## Requirements
- R1: Entries are accepted on `in_valid_i && in_ready_o`. `in_ready_o` is low only while all 8 slots hold entries. An offer made while full is dropped and never appears at the output.
- R2: An accepted entry whose ID differs from `cfg_qos_id_i` loads its countdown with `cfg_timeout_i`.
- R3: An accepted entry whose ID equals `cfg_qos_id_i` loads `cfg_qos_cnt_i` when `cfg_adapt_en_i` is 0, or when `qos_fast_i` is 0.
- R4: An accepted entry whose ID equals `cfg_qos_id_i` loads `cfg_qos_fast_cnt_i` when both `cfg_adapt_en_i` and `qos_fast_i` are 1. The fast pin has no effect on entries with other IDs.
- R5: A countdown loaded with L reads zero (the entry is expired) exactly L clock edges after the acceptance edge. It then stays at zero while the entry waits. `out_expired_o` is 1 when the offered entry is expired.
- R6: While any queued entry is expired, the offered entry is an expired one, even if an older entry has not yet expired.
- R7: Among several expired entries, the one accepted earliest is offered.
- R8: With no expired entry, the oldest queued entry is offered.
- R9: At most one entry leaves per cycle, on `out_valid_o && out_ready_i`. The offered entry stays unchanged while `out_ready_i` is low. The freed slot can accept a new entry from the next cycle on.
- R10: `chip_empty_o[c]` is 1 exactly when no queued entry has chip select c. Every bit is 1 after reset.
- R11: After reset the queue is empty: `out_valid_o` is 0 and `in_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Incoming transaction valid |
| in_ready_o | output | 1 | Queue can accept an entry |
| in_write_i | input | 1 | 1 = write, 0 = read |
| in_id_i | input | IdW | Transaction ID |
| in_chip_i | input | ChipW | Target chip select |
| in_addr_i | input | AddrW | Transaction address |
| out_valid_o | output | 1 | An entry is offered |
| out_ready_i | input | 1 | Memory side takes the offered entry |
| out_write_o | output | 1 | Offered entry direction |
| out_id_o | output | IdW | Offered entry ID |
| out_chip_o | output | ChipW | Offered entry chip select |
| out_addr_o | output | AddrW | Offered entry address |
| out_expired_o | output | 1 | Offered entry has aged out |
| cfg_timeout_i | input | CntW | Default countdown load value |
| cfg_qos_id_i | input | IdW | Priority transaction ID |
| cfg_qos_cnt_i | input | CntW | Load value for priority ID |
| cfg_qos_fast_cnt_i | input | CntW | Load value for priority ID in fast mode |
| cfg_adapt_en_i | input | 1 | Enables the fast-count selection |
| qos_fast_i | input | 1 | Requests the fast count at acceptance |
| chip_empty_o | output | NumChips | Per-chip no-entry flags |

## Verification
A wrong load selection or a faulty countdown shows up as `out_expired_o` rising at the wrong cycle. The bench therefore counts edges from acceptance to expiry and compares the count with the selected load value to the exact cycle. A corrupted age order shows up as the wrong ID or address being offered on the next pop. So every pop in the ordering tests is followed at once by an identity check. A stale valid or chip bit shows up within one cycle, either as a wrong `chip_empty_o` pattern or as an entry that should not exist appearing after the queue drains.

// File: rtl/cq_pkg.sv
package cq_pkg;
  localparam int unsigned DEF_DEPTH = 8;
  localparam int unsigned DEF_CNT_W = 12;

  typedef enum logic [1:0] {
    LOAD_DEFAULT,
    LOAD_QOS,
    LOAD_QOS_FAST
  } load_src_e;
endpackage

// File: rtl/cq_load_sel.sv
module cq_load_sel #(
  parameter int unsigned IdW  = 4,
  parameter int unsigned CntW = 12
) (
  input  logic [IdW-1:0]  id_i,
  input  logic [IdW-1:0]  qos_id_i,
  input  logic [CntW-1:0] timeout_i,
  input  logic [CntW-1:0] qos_cnt_i,
  input  logic [CntW-1:0] qos_fast_cnt_i,
  input  logic            adapt_en_i,
  input  logic            fast_i,
  output logic [CntW-1:0] load_o
);
  import cq_pkg::*;

  load_src_e src;

  always_comb begin
    if (id_i != qos_id_i)          src = LOAD_DEFAULT;
    else if (adapt_en_i && fast_i) src = LOAD_QOS_FAST;
    else                           src = LOAD_QOS;
  end

  always_comb begin
    unique case (src)
      LOAD_QOS:      load_o = qos_cnt_i;
      LOAD_QOS_FAST: load_o = qos_fast_cnt_i;
      default:       load_o = timeout_i;
    endcase
  end
endmodule

// File: rtl/cq_slot.sv
module cq_slot #(
  parameter int unsigned IdW   = 4,
  parameter int unsigned ChipW = 1,
  parameter int unsigned AddrW = 16,
  parameter int unsigned CntW  = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic             free_i,
  input  logic [CntW-1:0]  load_i,
  input  logic             write_i,
  input  logic [IdW-1:0]   id_i,
  input  logic [ChipW-1:0] chip_i,
  input  logic [AddrW-1:0] addr_i,
  output logic             valid_o,
  output logic             expired_o,
  output logic             write_o,
  output logic [IdW-1:0]   id_o,
  output logic [ChipW-1:0] chip_o,
  output logic [AddrW-1:0] addr_o
);
  logic            valid_q;
  logic [CntW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      cnt_q   <= '0;
      write_o <= 1'b0;
      id_o    <= '0;
      chip_o  <= '0;
      addr_o  <= '0;
    end else if (alloc_i) begin
      valid_q <= 1'b1;
      cnt_q   <= load_i;
      write_o <= write_i;
      id_o    <= id_i;
      chip_o  <= chip_i;
      addr_o  <= addr_i;
    end else if (free_i) begin
      valid_q <= 1'b0;
    end else if (valid_q && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign valid_o   = valid_q;
  assign expired_o = valid_q && (cnt_q == '0);
endmodule

// File: rtl/cq_age_pick.sv
module cq_age_pick #(
  parameter int unsigned Depth = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [Depth-1:0] alloc_i,
  input  logic [Depth-1:0] valid_i,
  input  logic [Depth-1:0] expired_i,
  output logic [Depth-1:0] grant_o
);
  // older_q[a][b]: slot a was filled before slot b
  logic [Depth-1:0] older_q [Depth];
  logic [Depth-1:0] cand;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < Depth; a++) older_q[a] <= '0;
    end else begin
      for (int k = 0; k < Depth; k++) begin
        if (alloc_i[k]) begin
          older_q[k] <= '0;
          for (int a = 0; a < Depth; a++)
            if (a != k) older_q[a][k] <= 1'b1;
        end
      end
    end
  end

  assign cand = (|expired_i) ? expired_i : valid_i;

  always_comb begin
    for (int b = 0; b < Depth; b++) begin
      grant_o[b] = cand[b];
      for (int a = 0; a < Depth; a++)
        if (a != b && cand[a] && older_q[a][b]) grant_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/cmdq_arb.sv
module cmdq_arb #(
  parameter int unsigned Depth    = cq_pkg::DEF_DEPTH,
  parameter int unsigned IdW      = 4,
  parameter int unsigned AddrW    = 16,
  parameter int unsigned NumChips = 2,
  parameter int unsigned CntW     = cq_pkg::DEF_CNT_W,
  localparam int unsigned ChipW   = (NumChips > 1) ? $clog2(NumChips) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic                in_write_i,
  input  logic [IdW-1:0]      in_id_i,
  input  logic [ChipW-1:0]    in_chip_i,
  input  logic [AddrW-1:0]    in_addr_i,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic                out_write_o,
  output logic [IdW-1:0]      out_id_o,
  output logic [ChipW-1:0]    out_chip_o,
  output logic [AddrW-1:0]    out_addr_o,
  output logic                out_expired_o,
  input  logic [CntW-1:0]     cfg_timeout_i,
  input  logic [IdW-1:0]      cfg_qos_id_i,
  input  logic [CntW-1:0]     cfg_qos_cnt_i,
  input  logic [CntW-1:0]     cfg_qos_fast_cnt_i,
  input  logic                cfg_adapt_en_i,
  input  logic                qos_fast_i,
  output logic [NumChips-1:0] chip_empty_o
);
  logic [Depth-1:0] valid, expired, grant, free_sel, alloc_vec, free_vec;
  logic [CntW-1:0]  load_val;
  logic             accept, issue;

  logic             s_write [Depth];
  logic [IdW-1:0]   s_id    [Depth];
  logic [ChipW-1:0] s_chip  [Depth];
  logic [AddrW-1:0] s_addr  [Depth];

  cq_load_sel #(.IdW(IdW), .CntW(CntW)) u_load (
    .id_i           (in_id_i),
    .qos_id_i       (cfg_qos_id_i),
    .timeout_i      (cfg_timeout_i),
    .qos_cnt_i      (cfg_qos_cnt_i),
    .qos_fast_cnt_i (cfg_qos_fast_cnt_i),
    .adapt_en_i     (cfg_adapt_en_i),
    .fast_i         (qos_fast_i),
    .load_o         (load_val)
  );

  assign in_ready_o = ~&valid;
  assign accept     = in_valid_i && in_ready_o;

  // lowest free slot takes the next entry
  always_comb begin
    logic found;
    found    = 1'b0;
    free_sel = '0;
    for (int i = 0; i < Depth; i++) begin
      if (!valid[i] && !found) begin
        free_sel[i] = 1'b1;
        found       = 1'b1;
      end
    end
  end

  assign alloc_vec = free_sel & {Depth{accept}};
  assign free_vec  = grant & {Depth{issue}};

  for (genvar g = 0; g < Depth; g++) begin : g_slot
    cq_slot #(.IdW(IdW), .ChipW(ChipW), .AddrW(AddrW), .CntW(CntW)) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .alloc_i   (alloc_vec[g]),
      .free_i    (free_vec[g]),
      .load_i    (load_val),
      .write_i   (in_write_i),
      .id_i      (in_id_i),
      .chip_i    (in_chip_i),
      .addr_i    (in_addr_i),
      .valid_o   (valid[g]),
      .expired_o (expired[g]),
      .write_o   (s_write[g]),
      .id_o      (s_id[g]),
      .chip_o    (s_chip[g]),
      .addr_o    (s_addr[g])
    );
  end

  cq_age_pick #(.Depth(Depth)) u_pick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .alloc_i   (alloc_vec),
    .valid_i   (valid),
    .expired_i (expired),
    .grant_o   (grant)
  );

  assign out_valid_o   = |valid;
  assign issue         = out_valid_o && out_ready_i;
  assign out_expired_o = |(grant & expired);

  always_comb begin
    out_write_o = 1'b0;
    out_id_o    = '0;
    out_chip_o  = '0;
    out_addr_o  = '0;
    for (int i = 0; i < Depth; i++) begin
      if (grant[i]) begin
        out_write_o = out_write_o | s_write[i];
        out_id_o    = out_id_o    | s_id[i];
        out_chip_o  = out_chip_o  | s_chip[i];
        out_addr_o  = out_addr_o  | s_addr[i];
      end
    end
  end

  for (genvar c = 0; c < NumChips; c++) begin : g_chip
    logic [Depth-1:0] hit;
    always_comb begin
      for (int i = 0; i < Depth; i++)
        hit[i] = valid[i] && (s_chip[i] == ChipW'(c));
    end
    assign chip_empty_o[c] = ~|hit;
  end
endmodule

// File: rtl/cmdq_arb_chk.sv
module cmdq_arb_chk #(
  parameter int unsigned NumChips = 2,
  localparam int unsigned ChipW   = (NumChips > 1) ? $clog2(NumChips) : 1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                in_valid_i,
  input logic                in_ready_o,
  input logic [ChipW-1:0]    in_chip_i,
  input logic                out_valid_o,
  input logic                out_ready_i,
  input logic                out_expired_o,
  input logic [NumChips-1:0] chip_empty_o
);
  logic             last_acc;
  logic [ChipW-1:0] last_chip;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_acc  <= 1'b0;
      last_chip <= '0;
    end else begin
      last_acc  <= in_valid_i && in_ready_o;
      last_chip <= in_chip_i;
    end
  end

  p_accept_shows_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o);

  p_expired_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_expired_o && !out_ready_i |=> out_expired_o);

  p_offer_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o);

  p_chip_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_acc |-> !chip_empty_o[last_chip]);

  p_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    &chip_empty_o |-> !out_valid_o && in_ready_o);
endmodule

bind cmdq_arb cmdq_arb_chk #(.NumChips(NumChips)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .in_valid_i    (in_valid_i),
  .in_ready_o    (in_ready_o),
  .in_chip_i     (in_chip_i),
  .out_valid_o   (out_valid_o),
  .out_ready_i   (out_ready_i),
  .out_expired_o (out_expired_o),
  .chip_empty_o  (chip_empty_o)
);

// File: tb/sim_cmdq_arb.sv
module sim_cmdq_arb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        in_valid = 0, in_ready, in_write = 0;
  logic [3:0]  in_id = 0;
  logic [0:0]  in_chip = 0;
  logic [15:0] in_addr = 0;
  logic        out_valid, out_ready = 0, out_write, out_expired;
  logic [3:0]  out_id;
  logic [0:0]  out_chip;
  logic [15:0] out_addr;
  logic [11:0] timeout = 12'd9, qcnt = 12'd4, qfast = 12'd1;
  logic [3:0]  qid = 4'd5;
  logic        adapt = 0, fast = 0;
  logic [1:0]  chip_empty;

  int errors = 0, checks = 0;

  cmdq_arb u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_write_i(in_write),
    .in_id_i(in_id), .in_chip_i(in_chip), .in_addr_i(in_addr),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_write_o(out_write),
    .out_id_o(out_id), .out_chip_o(out_chip), .out_addr_o(out_addr),
    .out_expired_o(out_expired),
    .cfg_timeout_i(timeout), .cfg_qos_id_i(qid), .cfg_qos_cnt_i(qcnt),
    .cfg_qos_fast_cnt_i(qfast), .cfg_adapt_en_i(adapt), .qos_fast_i(fast),
    .chip_empty_o(chip_empty)
  );

  typedef struct packed {
    logic [3:0]  id;
    logic        adapt;
    logic        fast;
    logic [11:0] exp;
  } vec_t;

  // timeout 9, priority id 5, priority count 4, fast count 1
  localparam vec_t VECS [6] = '{
    '{id: 4'd2, adapt: 1'b0, fast: 1'b0, exp: 12'd9},
    '{id: 4'd5, adapt: 1'b0, fast: 1'b0, exp: 12'd4},
    '{id: 4'd5, adapt: 1'b0, fast: 1'b1, exp: 12'd4},
    '{id: 4'd5, adapt: 1'b1, fast: 1'b0, exp: 12'd4},
    '{id: 4'd5, adapt: 1'b1, fast: 1'b1, exp: 12'd1},
    '{id: 4'd3, adapt: 1'b1, fast: 1'b1, exp: 12'd9}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] id, input logic chip, input logic [15:0] addr);
    @(negedge clk);
    in_valid = 1; in_id = id; in_chip = chip; in_addr = addr; in_write = id[0];
    @(posedge clk);
    #1 in_valid = 0;
  endtask

  task automatic pop();
    @(negedge clk);
    out_ready = 1;
    @(posedge clk);
    #1 out_ready = 0;
  endtask

  task automatic finish_sim();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_sim();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 out_valid after reset", int'(out_valid), 0);
    chk("R11 in_ready after reset", int'(in_ready), 1);
    chk("R10 chip_empty after reset", int'(chip_empty), 3);

    // table: load value selection measured as edges until expiry
    foreach (VECS[v]) begin
      int n;
      adapt = VECS[v].adapt;
      fast  = VECS[v].fast;
      push(VECS[v].id, 1'b0, 16'(v));
      n = 0;
      forever begin
        @(negedge clk);
        if (out_expired || n > 40) break;
        n++;
      end
      chk(VECS[v].id == 4'd5 ? (VECS[v].adapt && VECS[v].fast ? "R4 fast load" : "R3 qos load")
                             : (VECS[v].fast ? "R4 fast ignored" : "R2 default load"),
          n, int'(VECS[v].exp));
      chk("R5 expired entry offered", int'(out_addr), v);
      pop();
      @(negedge clk);
      chk("R9 slot freed after pop", int'(out_valid), 0);
    end
    adapt = 0; fast = 0;

    // R8 oldest first, R10 per-chip flags
    timeout = 12'd100; qid = 4'd15;
    push(4'd1, 1'b0, 16'h11);
    push(4'd2, 1'b1, 16'h22);
    push(4'd3, 1'b0, 16'h33);
    @(negedge clk);
    chk("R10 both chips busy", int'(chip_empty), 0);
    chk("R8 oldest offered", int'(out_id), 1);
    @(negedge clk);
    chk("R9 offer held while not ready", int'(out_addr), 16'h11);
    pop();
    @(negedge clk);
    chk("R8 next oldest", int'(out_id), 2);
    pop();
    @(negedge clk);
    chk("R8 last entry", int'(out_id), 3);
    chk("R10 chip1 empty only", int'(chip_empty), 2);
    pop();
    @(negedge clk);
    chk("R10 all empty again", int'(chip_empty), 3);

    // R1 full, dropped offer; R9 refill
    for (int i = 0; i < 8; i++) push(4'(i), 1'(i), 16'(i));
    @(negedge clk);
    chk("R1 not ready when full", int'(in_ready), 0);
    push(4'd9, 1'b0, 16'h99);
    pop();
    @(negedge clk);
    chk("R9 ready after pop", int'(in_ready), 1);
    chk("R8 oldest after pop", int'(out_id), 1);
    push(4'd10, 1'b0, 16'hAA);
    @(negedge clk);
    chk("R1 full again after refill", int'(in_ready), 0);
    for (int i = 1; i < 9; i++) begin
      @(negedge clk);
      chk("R1 drain order", int'(out_id), i < 8 ? i : 10);
      pop();
    end
    @(negedge clk);
    chk("R1 dropped offer absent", int'(out_valid), 0);

    // R6/R7 expired beats oldest; earliest expired first
    qid = 4'd5;
    push(4'd2, 1'b0, 16'hA0);
    push(4'd5, 1'b0, 16'hB0);
    push(4'd5, 1'b1, 16'hC0);
    @(negedge clk);
    chk("R8 oldest before expiry", int'(out_addr), 16'hA0);
    chk("R5 not yet expired", int'(out_expired), 0);
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk("R6 expired outranks oldest", int'(out_expired), 1);
    chk("R7 earliest expired wins", int'(out_addr), 16'hB0);
    pop();
    @(negedge clk);
    chk("R7 second expired", int'(out_addr), 16'hC0);
    chk("R5 stays expired", int'(out_expired), 1);
    pop();
    @(negedge clk);
    chk("R8 remaining unexpired", int'(out_addr), 16'hA0);
    chk("R5 remaining not expired", int'(out_expired), 0);
    pop();
    @(negedge clk);
    chk("R11 queue empty at end", int'(out_valid), 0);

    finish_sim();
  end
endmodule